// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address for one port of a synchronous memory. At every rising clock edge it samples its control inputs into registers. From those registered controls and the address it used last, it forms the address for the present cycle. Four sources compete for that address, and the choice follows a fixed priority. Zero wins over everything else. An externally supplied address comes next. Then comes the last address plus one. If none of these applies, the last address is reused unchanged.

The address leaves the block combinationally from the registered controls. A synchronous RAM read can therefore start on it in the same cycle. Each address becomes the stored value for the next decision. A burst is started by presenting a start address with the load strobe, and the advance enable then steps it.

The port's select and byte-lane enables are wired in but have no effect on the address. Deselecting the port neither freezes the counter nor blocks a load.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_out` is 0 and `addr_valid` is 0. A few cycles after release, `addr_valid` is 1 and, with all controls inactive (high), `addr_out` stays 0.
- R2: When `clr_n` is low at an edge, the address for the following cycle is 0, whatever `load_n`, `adv_n` and `ext_addr` are.
- R3: A clear costs no dead cycle: the cycle right after a clear cycle can already load or step, and stepping after a clear gives address 1.
- R4: With `clr_n` high and `load_n` low at an edge, the address for the following cycle equals `ext_addr` sampled at that edge.
- R5: With `clr_n` and `load_n` high and `adv_n` low at an edge, the address becomes the previous address plus one.
- R6: With `clr_n`, `load_n` and `adv_n` all high, the previous address is repeated unchanged.
- R7: Load takes priority over advance: when both `load_n` and `adv_n` are low, the loaded value is used and is not incremented.
- R8: Stepping from 16'hFFFF gives 16'h0000.
- R9: `port_sel_n` and `lane_en` have no effect on the address in any mode.
- R10: Controls sampled at edge k determine `addr_out` from just after edge k until edge k+1, with one register stage on the way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_addr | input | 16 | Address presented from outside for a load |
| load_n | input | 1 | Active-low strobe that takes `ext_addr` |
| adv_n | input | 1 | Active-low enable that steps the stored address |
| clr_n | input | 1 | Active-low clear that forces address 0 |
| port_sel_n | input | 1 | Port select, has no effect on the address |
| lane_en | input | 2 | Byte-lane enables, have no effect on the address |
| addr_out | output | 16 | Address used in the current cycle |
| addr_valid | output | 1 | High in every cycle after reset has been released |

## Verification
The directed cases target the points where priority and timing go wrong:
- A clear issued together with load and advance must give 0. A design with the priority reversed returns the external address or an increment instead.
- A step taken right after a clear must give 1. A design that inserts a dead cycle gives 0 again.
- A combined load and advance must give the plain loaded value. A design that adds one to a load is caught here.
- A step from 16'hFFFF must give 0. A design that saturates sticks at 16'hFFFF.

Long random mixes of all controls, with the select and lane enables toggled at random, catch any coupling of the enables into the counter. Such a coupling shows up as a frozen or skipped address.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int unsigned ADDR_W_DEF = 16;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2,
    OP_ZERO = 2'd3
  } addr_op_e;

  // fixed priority: clear, then load, then step, then hold
  function automatic addr_op_e decode_op(input logic clr_n, input logic load_n,
                                         input logic adv_n);
    if (!clr_n)       return OP_ZERO;
    else if (!load_n) return OP_LOAD;
    else if (!adv_n)  return OP_STEP;
    else              return OP_HOLD;
  endfunction
endpackage

// File: rtl/reset_sync.sv
module reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign run_n = chain_q[LAST];
endmodule

// File: rtl/ctl_capture.sv
module ctl_capture
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              run_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic              clr_n,
  output addr_op_e          op,
  output logic [ADDR_W-1:0] ext_q
);
  logic              load_q, adv_q, clr_q;
  logic [ADDR_W-1:0] ext_d;
  logic              load_d, adv_d, clr_d;

  always_comb begin
    ext_d  = ext_addr;
    load_d = load_n;
    adv_d  = adv_n;
    clr_d  = clr_n;
  end

  // reset to the inactive (hold) level of every control
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      ext_q  <= '0;
      load_q <= 1'b1;
      adv_q  <= 1'b1;
      clr_q  <= 1'b1;
    end else begin
      ext_q  <= ext_d;
      load_q <= load_d;
      adv_q  <= adv_d;
      clr_q  <= clr_d;
    end
  end

  always_comb begin
    op = decode_op(clr_q, load_q, adv_q);
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!run_n)
    !clr_n |=> (op == OP_ZERO)); // R2
  AST_LOAD_OVER_STEP: assert property (@(posedge clk) disable iff (!run_n)
    (clr_n && !load_n && !adv_n) |=> (op == OP_LOAD)); // R7
endmodule

// File: rtl/addr_select.sv
module addr_select
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              run_n,
  input  addr_op_e          op,
  input  logic [ADDR_W-1:0] ext_q,
  input  logic [ADDR_W-1:0] prev_q,
  output logic [ADDR_W-1:0] addr_now
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    unique case (op)
      OP_ZERO: addr_now = '0;
      OP_LOAD: addr_now = ext_q;
      OP_STEP: addr_now = prev_q + ONE;
      default: addr_now = prev_q;
    endcase
  end

  AST_ZERO_SEL: assert property (@(posedge clk) disable iff (!run_n)
    (op == OP_ZERO) |-> (addr_now == '0)); // R2
  AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!run_n)
    (op == OP_HOLD) |-> (addr_now == prev_q)); // R6
endmodule

// File: rtl/addr_hold.sv
module addr_hold #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              run_n,
  input  logic [ADDR_W-1:0] addr_now,
  output logic [ADDR_W-1:0] prev_q,
  output logic              valid_q
);
  logic              upd_en;
  logic [ADDR_W-1:0] prev_d;
  logic              valid_d;

  always_comb begin
    upd_en  = run_n;
    prev_d  = upd_en ? addr_now : prev_q;
    valid_d = upd_en ? 1'b1 : valid_q;
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      prev_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      valid_q <= valid_d;
    end
  end

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!run_n)
    valid_q |=> valid_q); // R1
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic              clr_n,
  input  logic              port_sel_n,
  input  logic [1:0]        lane_en,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic              run_n;
  addr_op_e          op;
  logic [ADDR_W-1:0] ext_q;
  logic [ADDR_W-1:0] prev_q;
  logic [ADDR_W-1:0] addr_now;
  logic              valid_q;

  reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  ctl_capture #(.ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .run_n    (run_n),
    .ext_addr (ext_addr),
    .load_n   (load_n),
    .adv_n    (adv_n),
    .clr_n    (clr_n),
    .op       (op),
    .ext_q    (ext_q)
  );

  addr_select #(.ADDR_W(ADDR_W)) u_sel (
    .clk      (clk),
    .run_n    (run_n),
    .op       (op),
    .ext_q    (ext_q),
    .prev_q   (prev_q),
    .addr_now (addr_now)
  );

  addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk      (clk),
    .run_n    (run_n),
    .addr_now (addr_now),
    .prev_q   (prev_q),
    .valid_q  (valid_q)
  );

  assign addr_out   = addr_now;
  assign addr_valid = valid_q;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!run_n)
    (valid_q && !clr_n) |=> (addr_out == '0)); // R2
  AST_LOAD_EXT: assert property (@(posedge clk) disable iff (!run_n)
    (valid_q && clr_n && !load_n) |=> (addr_out == $past(ext_addr))); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!run_n)
    (valid_q && clr_n && load_n && !adv_n) |=> (addr_out == $past(addr_out) + ONE)); // R5
  AST_HOLD_SAME: assert property (@(posedge clk) disable iff (!run_n)
    (valid_q && clr_n && load_n && adv_n && port_sel_n) |=> $stable(addr_out)); // R9
  AST_LANES_NO_BLOCK: assert property (@(posedge clk) disable iff (!run_n)
    (valid_q && clr_n && !load_n && (lane_en == 2'b00)) |=> (addr_out == $past(ext_addr))); // R9
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ext_addr;
  logic        load_n, adv_n, clr_n, port_sel_n;
  logic [1:0]  lane_en;
  logic [15:0] addr_out;
  logic        addr_valid;

  int checks = 0;
  int errors = 0;
  logic [15:0] model_addr = 16'h0000;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  burst_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .load_n(load_n),
    .adv_n(adv_n), .clr_n(clr_n), .port_sel_n(port_sel_n), .lane_en(lane_en),
    .addr_out(addr_out), .addr_valid(addr_valid)
  );

  function automatic logic [15:0] next_addr(input logic [15:0] prev, input logic c,
                                            input logic l, input logic a,
                                            input logic [15:0] ext);
    if (!c)      return 16'h0000;
    else if (!l) return ext;
    else if (!a) return prev + 16'h0001;
    else         return prev;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at falling edge, let one rising edge capture, check at next falling edge
  task automatic step(input string req, input logic c, input logic l, input logic a,
                      input logic [15:0] ext, input logic sel, input logic [1:0] ln);
    clr_n = c; load_n = l; adv_n = a; ext_addr = ext; port_sel_n = sel; lane_en = ln;
    model_addr = next_addr(model_addr, c, l, a, ext);
    @(posedge clk);
    @(negedge clk);
    check(req, addr_out, model_addr);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_addr = 16'h0; load_n = 1'b1; adv_n = 1'b1; clr_n = 1'b1;
    port_sel_n = 1'b0; lane_en = 2'b11;
    repeat (3) @(negedge clk);
    check("R1 reset addr", addr_out, 16'h0000);
    check("R1 reset valid", {15'b0, addr_valid}, 16'h0001 ^ 16'h0001);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 valid after release", {15'b0, addr_valid}, 16'h0001);
    check("R1 addr after release", addr_out, 16'h0000);

    step("R4 load",              1, 0, 1, 16'h1234, 0, 2'b11);
    step("R10 load timing",      1, 1, 1, 16'h0BAD, 0, 2'b11);
    step("R5 advance",           1, 1, 0, 16'h0BAD, 0, 2'b11);
    step("R6 hold",              1, 1, 1, 16'h7777, 0, 2'b11);
    step("R2 clear over all",    0, 0, 0, 16'h5555, 0, 2'b11);
    step("R3 step after clear",  1, 1, 0, 16'h5555, 0, 2'b11);
    step("R3 load after clear",  0, 1, 1, 16'h0000, 0, 2'b11);
    step("R3 load after clear",  1, 0, 1, 16'hABCD, 0, 2'b11);
    step("R8 load top",          1, 0, 1, 16'hFFFF, 0, 2'b11);
    step("R8 wrap",              1, 1, 0, 16'h0000, 0, 2'b11);
    step("R7 load over advance", 1, 0, 0, 16'h4000, 0, 2'b11);
    step("R9 step deselected",   1, 1, 0, 16'h0000, 1, 2'b00);
    step("R9 load deselected",   1, 0, 1, 16'h0F0F, 1, 2'b00);
    step("R9 clear deselected",  0, 1, 1, 16'h0F0F, 1, 2'b01);

    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] pick;
      logic c, l, a;
      pick = 4'($urandom_range(0, 15));
      c = (pick != 0);
      l = (pick > 3) ? 1'b1 : 1'b0;
      a = (pick[0] | pick[1]) ? 1'b0 : 1'b1;
      if (pick > 11) begin l = 1'b1; a = 1'b1; end
      step("R9 random mix", c, l, a, 16'($urandom),
           1'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule